// File: doc/BRIEF.md
# Wide-to-Narrow Block Stream Buffer

This block sits between a wide shared memory and one consumer inside a core, such as an instruction streamer or a pixel feeder. The memory side hands over a whole block of sixteen 32-bit longs (512 bits) in a single clock. The consumer side takes that block back out one long per clock through a valid/ready handshake. Longs leave in ascending order, starting with long 0, which sits in bits 31:0 of the block.

A start command arms the buffer with a block address. The buffer then keeps a request line high with the address of the next block it wants, and the memory answers with a load strobe when its slot comes round, once every sixteen clocks. Each accepted block advances the request address by 64 bytes. A second 512-bit holding register accepts the next block while the current one is still being read out, so the stream has no gap at block boundaries.

A block that arrives while both registers are full is dropped and a sticky overrun flag is raised. A stop command clears all buffered data and flags. A core that streams both code and video uses two separate copies of this block.

Top module: `block_stream_buf`

## Requirements
- R1: After reset, outValid, reqValid and overrun are all 0.
- R2: One clock after startCmd, reqValid is 1 and reqAddr equals startAddr with its six low bits forced to zero (64-byte block alignment).
- R3: A loadStrobe that finds both registers empty captures all 512 bits of loadData in that clock. On the next clock outValid is 1 and outData holds loadData[31:0].
- R4: Long k of a block is loadData[32k+31:32k], and longs leave in order k = 0..15. The index advances only on a clock where outValid and outReady are both 1. While outReady is 0, outData and outValid stay unchanged.
- R5: Each accepted block increments reqAddr by 64, wrapping modulo 2^ADDR_W. A dropped block leaves reqAddr unchanged.
- R6: A block loaded while another is draining is held. On the clock after long 15 is consumed, outValid stays 1 and outData shows long 0 of the held block.
- R7: reqValid is 0 while both the output register and the holding register are full, and 1 otherwise while the buffer is armed.
- R8: A loadStrobe that arrives while both registers stay full sets overrun. Overrun stays set until the next startCmd or stopCmd. The dropped block never reaches outData, and the buffered stream continues unchanged.
- R9: One clock after stopCmd, outValid, reqValid and overrun are 0. While the buffer is stopped, loadStrobe is ignored.
- R10: startCmd discards any buffered data, clears overrun and loads the new address. stopCmd takes priority if both are asserted together.
- R11: Suppose long 15 is consumed in the same clock as a loadStrobe while the holding register is full. The held block moves to the output, the new block is held, and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Arm the buffer at startAddr and discard buffered data |
| startAddr | input | ADDR_W | Byte address of the first block |
| stopCmd | input | 1 | Disarm the buffer and clear all valid state |
| reqValid | output | 1 | The buffer wants another block |
| reqAddr | output | ADDR_W | Byte address of the next block wanted |
| loadStrobe | input | 1 | loadData carries a block this clock |
| loadData | input | LONG_W*LONGS | The whole block, long 0 in the low bits |
| outData | output | LONG_W | Current long toward the consumer |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | The consumer takes outData this clock |
| overrun | output | 1 | Sticky: a block was dropped |

## Verification
Suppose the read index is wrong. The wrong long shows at outData within one handshake, and the missing or extra long appears as a shifted long at the next block boundary. Suppose the occupancy of the two registers is tracked wrongly. Within one strobe, that shows either as reqValid still high when both registers are full, or as overrun rising with one register still free. It can also show as a one-clock drop of outValid at the block boundary, or as long 0 of a dropped block appearing at outData. Suppose the address counter is off. reqAddr shows it on the clock after the next strobe, including across the wrap from the top block to zero.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  // Strobes issued by the control unit to the datapath each clock
  typedef struct packed {
    logic drainFromHold;  // copy holding register into output register
    logic drainFromLoad;  // capture loadData into output register
    logic holdFromLoad;   // capture loadData into holding register
  } bsbStrobes_t;

endpackage

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
#(
  parameter int LONGS       = 16,
  parameter int ADDR_W      = 20,
  parameter int BLOCK_BYTES = 64,
  localparam int IDX_W      = $clog2(LONGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              stopCmd,
  input  logic              loadStrobe,
  input  logic              outReady,
  output bsbStrobes_t       strobes,
  output logic [IDX_W-1:0]  readIdx,
  output logic              outValid,
  output logic              holdFull,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              overrun
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LONGS - 1);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(BLOCK_BYTES - 1);

  logic              active;
  logic              drainFull;
  logic [ADDR_W-1:0] nextAddr;

  logic clearAll, pop, lastPop;
  logic drainAfter, holdAfter;
  logic loadOk, toDrain, toHold, dropBlk;

  always_comb begin
    clearAll = stopCmd || startCmd;
    pop      = drainFull && outReady;
    lastPop  = pop && (readIdx == LAST_IDX);

    // Occupancy once this clock's consumption is accounted for
    if (lastPop) begin
      drainAfter = holdFull;
      holdAfter  = 1'b0;
    end else begin
      drainAfter = drainFull;
      holdAfter  = holdFull;
    end

    loadOk  = active && loadStrobe && !clearAll;
    toDrain = loadOk && !drainAfter;
    toHold  = loadOk && drainAfter && !holdAfter;
    dropBlk = loadOk && drainAfter && holdAfter;

    strobes.drainFromHold = lastPop && holdFull && !clearAll;
    strobes.drainFromLoad = toDrain;
    strobes.holdFromLoad  = toHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      drainFull <= 1'b0;
      holdFull  <= 1'b0;
      readIdx   <= '0;
      overrun   <= 1'b0;
      nextAddr  <= '0;
    end else begin
      if (stopCmd)       active <= 1'b0;
      else if (startCmd) active <= 1'b1;

      if (clearAll) begin
        drainFull <= 1'b0;
        holdFull  <= 1'b0;
        readIdx   <= '0;
        overrun   <= 1'b0;
      end else begin
        drainFull <= drainAfter || toDrain;
        holdFull  <= holdAfter || toHold;
        if (lastPop)  readIdx <= '0;
        else if (pop) readIdx <= readIdx + IDX_W'(1);
        if (dropBlk)  overrun <= 1'b1;
      end

      if (startCmd && !stopCmd)  nextAddr <= startAddr & ALIGN_MSK;
      else if (toDrain || toHold) nextAddr <= nextAddr + ADDR_STEP;
    end
  end

  assign outValid = drainFull;
  assign reqValid = active && !(drainFull && holdFull);
  assign reqAddr  = nextAddr;

endmodule

// File: rtl/bsb_datapath.sv
module bsb_datapath
  import bsb_pkg::*;
#(
  parameter int LONG_W  = 32,
  parameter int LONGS   = 16,
  localparam int IDX_W  = $clog2(LONGS),
  localparam int BLOCK_W = LONG_W * LONGS
) (
  input  logic               clk,
  input  bsbStrobes_t        strobes,
  input  logic [BLOCK_W-1:0] loadData,
  input  logic [IDX_W-1:0]   readIdx,
  output logic [LONG_W-1:0]  outData
);

  logic [LONG_W-1:0] loadLongs [LONGS];
  logic [LONG_W-1:0] drainRegs [LONGS];
  logic [LONG_W-1:0] holdRegs  [LONGS];

  for (genvar k = 0; k < LONGS; k++) begin : g_lane
    assign loadLongs[k] = loadData[k*LONG_W +: LONG_W];

    always_ff @(posedge clk) begin
      if (strobes.drainFromLoad)      drainRegs[k] <= loadLongs[k];
      else if (strobes.drainFromHold) drainRegs[k] <= holdRegs[k];
      if (strobes.holdFromLoad)       holdRegs[k]  <= loadLongs[k];
    end
  end

  assign outData = drainRegs[readIdx];

endmodule

// File: rtl/block_stream_buf.sv
module block_stream_buf
  import bsb_pkg::*;
#(
  parameter int LONG_W = 32,
  parameter int LONGS  = 16,
  parameter int ADDR_W = 20,
  localparam int BLOCK_W     = LONG_W * LONGS,
  localparam int BLOCK_BYTES = BLOCK_W / 8,
  localparam int IDX_W       = $clog2(LONGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCmd,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic               stopCmd,
  output logic               reqValid,
  output logic [ADDR_W-1:0]  reqAddr,
  input  logic               loadStrobe,
  input  logic [BLOCK_W-1:0] loadData,
  output logic [LONG_W-1:0]  outData,
  output logic               outValid,
  input  logic               outReady,
  output logic               overrun
);

  bsbStrobes_t      strobes;
  logic [IDX_W-1:0] readIdx;
  logic             holdFull;

  bsb_ctrl #(
    .LONGS(LONGS), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startCmd(startCmd), .startAddr(startAddr), .stopCmd(stopCmd),
    .loadStrobe(loadStrobe), .outReady(outReady),
    .strobes(strobes), .readIdx(readIdx),
    .outValid(outValid), .holdFull(holdFull),
    .reqValid(reqValid), .reqAddr(reqAddr), .overrun(overrun)
  );

  bsb_datapath #(
    .LONG_W(LONG_W), .LONGS(LONGS)
  ) u_data (
    .clk(clk), .strobes(strobes), .loadData(loadData),
    .readIdx(readIdx), .outData(outData)
  );

endmodule

// File: rtl/bsb_checker.sv
module bsb_checker #(
  parameter int LONG_W = 32,
  parameter int ADDR_W = 20,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              stopCmd,
  input logic              loadStrobe,
  input logic              outReady,
  input logic              outValid,
  input logic [LONG_W-1:0] outData,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              overrun,
  input logic              holdFull
);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !startCmd && !stopCmd) |=> (outValid && $stable(outData))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && loadStrobe && !startCmd && !stopCmd) |=>
      (reqAddr == $past(reqAddr) + ADDR_W'(BLOCK_BYTES))); // R5

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && holdFull && !startCmd && !stopCmd) |=> outValid); // R6

  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && holdFull) |-> !reqValid); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !startCmd && !stopCmd) |=> overrun); // R8

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (!outValid && !reqValid && !overrun)); // R9

endmodule

bind block_stream_buf bsb_checker #(
  .LONG_W(LONG_W), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
  .loadStrobe(loadStrobe), .outReady(outReady), .outValid(outValid),
  .outData(outData), .reqValid(reqValid), .reqAddr(reqAddr),
  .overrun(overrun), .holdFull(holdFull)
);

// File: tb/tb_block_stream_buf.sv
module tb_block_stream_buf;
  localparam int LONG_W = 32, LONGS = 16, ADDR_W = 20;
  localparam int BLOCK_W = LONG_W * LONGS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCmd = 1'b0, stopCmd = 1'b0, loadStrobe = 1'b0, outReady = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [BLOCK_W-1:0] loadData = '0;
  logic reqValid, outValid, overrun;
  logic [ADDR_W-1:0] reqAddr;
  logic [LONG_W-1:0] outData;

  int errors = 0, checks = 0;

  always #10 clk = ~clk; // 50 MHz

  block_stream_buf #(.LONG_W(LONG_W), .LONGS(LONGS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .startAddr(startAddr),
    .stopCmd(stopCmd), .reqValid(reqValid), .reqAddr(reqAddr),
    .loadStrobe(loadStrobe), .loadData(loadData), .outData(outData),
    .outValid(outValid), .outReady(outReady), .overrun(overrun));

  function automatic logic [31:0] longOf(int b, int k);
    return 32'hC0DE0000 ^ 32'(b << 8) ^ 32'(k);
  endfunction

  function automatic logic [BLOCK_W-1:0] blockOf(int b);
    logic [BLOCK_W-1:0] v;
    for (int k = 0; k < LONGS; k++) v[k*LONG_W +: LONG_W] = longOf(b, k);
    return v;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseLoad(int b);
    loadData = blockOf(b); loadStrobe = 1'b1; tick(); loadStrobe = 1'b0;
  endtask

  // Stall/consume pattern over one block: {ready, expected long index shown}
  localparam int NVEC = 8;
  localparam logic [4:0] VEC [NVEC] = '{
    {1'b0, 4'd0}, {1'b1, 4'd0}, {1'b1, 4'd1}, {1'b0, 4'd2},
    {1'b0, 4'd2}, {1'b1, 4'd2}, {1'b1, 4'd3}, {1'b1, 4'd4}};

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 reqValid", 64'(reqValid), 64'd0);
    check("R1 overrun",  64'(overrun),  64'd0);
    rstN = 1'b1; tick();

    // R9: loads ignored while never armed
    pulseLoad(7);
    check("R9 idle load ignored", 64'(outValid), 64'd0);

    startAddr = 20'h01234; startCmd = 1'b1; tick(); startCmd = 1'b0;
    check("R2 reqValid", 64'(reqValid), 64'd1);
    check("R2 reqAddr aligned", 64'(reqAddr), 64'h01200);

    pulseLoad(1);
    check("R3 outValid", 64'(outValid), 64'd1);
    check("R3 long0", 64'(outData), 64'(longOf(1, 0)));
    check("R5 step", 64'(reqAddr), 64'h01240);

    // Table walk: ordering and stall behaviour
    for (int i = 0; i < NVEC; i++) begin
      outReady = VEC[i][4];
      check("R4 order/stall data", 64'(outData), 64'(longOf(1, int'(VEC[i][3:0]))));
      check("R4 valid", 64'(outValid), 64'd1);
      tick();
    end
    outReady = 1'b0;

    pulseLoad(2);
    check("R5 step on held load", 64'(reqAddr), 64'h01280);
    check("R7 no request when full", 64'(reqValid), 64'd0);
    check("R4 stalled data", 64'(outData), 64'(longOf(1, 5)));

    pulseLoad(9);
    check("R8 overrun set", 64'(overrun), 64'd1);
    check("R5/R8 addr kept on drop", 64'(reqAddr), 64'h01280);
    check("R8 stream unchanged", 64'(outData), 64'(longOf(1, 5)));

    outReady = 1'b1;
    repeat (10) tick();
    check("R4 long15", 64'(outData), 64'(longOf(1, 15)));
    tick();
    check("R6 no gap valid", 64'(outValid), 64'd1);
    check("R6 held block long0", 64'(outData), 64'(longOf(2, 0)));
    check("R7 request after free", 64'(reqValid), 64'd1);
    check("R8 overrun sticky", 64'(overrun), 64'd1);
    tick();
    check("R8 dropped block never shown", 64'(outData), 64'(longOf(2, 1)));
    outReady = 1'b0;

    stopCmd = 1'b1; tick(); stopCmd = 1'b0;
    check("R9 outValid", 64'(outValid), 64'd0);
    check("R9 reqValid", 64'(reqValid), 64'd0);
    check("R9 overrun", 64'(overrun), 64'd0);
    pulseLoad(6);
    check("R9 load ignored stopped", 64'(outValid), 64'd0);

    startAddr = 20'hFFFC0; startCmd = 1'b1; tick(); startCmd = 1'b0;
    check("R10 addr", 64'(reqAddr), 64'hFFFC0);
    check("R10 empty", 64'(outValid), 64'd0);
    pulseLoad(3);
    check("R5 wrap", 64'(reqAddr), 64'h00000);
    check("R3 new long0", 64'(outData), 64'(longOf(3, 0)));
    pulseLoad(4);
    check("R7 full again", 64'(reqValid), 64'd0);
    outReady = 1'b1;
    repeat (15) tick();
    check("R4 long15 blk3", 64'(outData), 64'(longOf(3, 15)));
    loadData = blockOf(5); loadStrobe = 1'b1; tick(); loadStrobe = 1'b0;
    check("R11 handoff data", 64'(outData), 64'(longOf(4, 0)));
    check("R11 no overrun", 64'(overrun), 64'd0);
    check("R11 both full", 64'(reqValid), 64'd0);
    check("R11 addr", 64'(reqAddr), 64'h00080);
    tick();
    check("R11 next long", 64'(outData), 64'(longOf(4, 1)));

    // Restart mid-stream, stop wins over simultaneous start
    startAddr = 20'h00100; startCmd = 1'b1; stopCmd = 1'b1; tick();
    stopCmd = 1'b0; startCmd = 1'b0;
    check("R10 stop priority", 64'(reqValid), 64'd0);
    startCmd = 1'b1; tick(); startCmd = 1'b0;
    check("R10 restart cleared", 64'(outValid), 64'd0);
    check("R10 restart addr", 64'(reqAddr), 64'h00100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule